// File: doc/BRIEF.md
# Byte/Halfword Register ALU with Carry Spill

This block computes the new value of a 16-bit destination register for three instruction classes of a small control processor. The first is the register-to-register arithmetic and logic class. The second is the immediate bit-manipulation class. The third is the right-shift/rotate group. The caller presents an opcode nibble, a modifier nibble, the current destination value, a source value and an 8-bit immediate. One cycle later the block returns the result and a write enable for the register file.

The block has no flags register. In byte arithmetic, the high byte of the destination holds the carry or borrow. A plain add increments the high byte on a carry. A plain subtract decrements it on a borrow. The two special adds then fold that high byte back into the next byte of a multi-byte field. In the same spirit, the plain shift fills its vacated bit from the high byte, so two operations make a 16-bit shift.

Codes that the block does not own are rejected. This covers other opcodes, the device-transfer modifiers, and the shift opcode with a non-shift modifier. For these the write enable stays low.

Top module: `spill_alu`

## Requirements
- R1: While rst_ni is low, result_o is 0 and we_o is 0.
- R2: An operation presented with valid_i high appears on result_o and we_o on the next clock edge. When valid_i is low, we_o is 0 on the next edge and result_o keeps its previous value.
- R3: Opcode 0 with modifier 0, 1, 2, 3 or 4 writes the full 16-bit source plus -2, -1, +1, +2 or 0 respectively, modulo 2^16.
- R4: Opcode 0 with modifier 5, 6 or 7 writes the AND, OR or XOR of the two low bytes into the low byte. The destination high byte is kept.
- R5: Opcode 0 with modifier 8 writes the low byte of dst_lo+src_lo. A carry out adds 1 (mod 256) to the destination high byte.
- R6: Opcode 0 with modifier 9 writes the low byte of dst_lo-src_lo. A borrow subtracts 1 (mod 256) from the destination high byte.
- R7: Opcode 0 with modifier A writes dst_hi+src_lo (mod 256) into the low byte. The high byte becomes 1 on a carry and 0 otherwise.
- R8: Opcode 0 with modifier B writes dst_hi+src_lo (mod 256) into the low byte. The high byte becomes 00 on a carry and FF otherwise.
- R9: Opcode 0 with modifier C copies src_hi into the destination low byte. Modifier D copies src_lo into the destination high byte. The other destination byte is kept in both cases.
- R10: Opcode A adds imm+1 to dst_lo and carries into the high byte. Opcode F subtracts imm+1 from dst_lo and borrows from the high byte.
- R11: Opcode 8 writes imm to the low byte. Opcode 9 clears the low-byte bits where imm is 1. Opcode B sets those bits. The high byte is kept in all three.
- R12: Opcode E acts on the destination low byte and keeps the high byte. Modifier C shifts right by 1 and fills bit 7 with dst bit 8. Modifiers D, E and F rotate right by 1, 3 and 4 (11010001 rotated by 3 gives 00111010).
- R13: Any other code gives we_o low and result_o unchanged. This covers opcode 0 with modifier E or F, opcode E with modifier below C, and opcodes other than 0, 8, 9, A, B, E and F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode nibble |
| mod_i | input | 4 | Modifier nibble |
| dst_i | input | 16 | Current destination value |
| src_i | input | 16 | Source register value |
| imm_i | input | 8 | Immediate byte or bit mask |
| result_o | output | 16 | New destination value |
| we_o | output | 1 | Destination write enable |

## Verification
Directed vectors target the carry and borrow boundaries:
- 0xFF+0x01 for add-with-carry.
- 0x00-0x01 for subtract-with-borrow.
- A high byte of FF, to show that the spill wraps.
- 0x0000 and 0xFFFF for the move offsets, which must wrap modulo 2^16.

The special adds are tried both with and without a carry, which separates the 0/1 result of modifier A from the 00/FF result of modifier B. The shift is tried with dst bit 8 both set and clear, which separates the padded shift from the 1-bit rotate. After that, a long stream of random codes and operands checks every output cycle against a behavioural integer model. This includes the rejected codes and idle cycles, where the held result must not move.

// File: rtl/spill_alu_pkg.sv
package spill_alu_pkg;
  localparam logic [3:0] OP_REG  = 4'h0;
  localparam logic [3:0] OP_EMIT = 4'h8;
  localparam logic [3:0] OP_CLR  = 4'h9;
  localparam logic [3:0] OP_ADDI = 4'hA;
  localparam logic [3:0] OP_SET  = 4'hB;
  localparam logic [3:0] OP_SHFT = 4'hE;
  localparam logic [3:0] OP_SUBI = 4'hF;

  typedef enum logic [3:0] {
    M_MVM2 = 4'h0, M_MVM1 = 4'h1, M_MVP1 = 4'h2, M_MVP2 = 4'h3,
    M_MOV  = 4'h4, M_AND  = 4'h5, M_OR   = 4'h6, M_XOR  = 4'h7,
    M_ADD  = 4'h8, M_SUB  = 4'h9, M_ADS1 = 4'hA, M_ADS2 = 4'hB,
    M_H2L  = 4'hC, M_L2H  = 4'hD, M_RSV0 = 4'hE, M_RSV1 = 4'hF
  } reg_mod_e;
endpackage

// File: rtl/spill_alu_move.sv
module spill_alu_move #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] src_i,
  input  logic [3:0]   mod_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (mod_i[2:0])
      3'd0:    res_o = src_i - W'(2);
      3'd1:    res_o = src_i - W'(1);
      3'd2:    res_o = src_i + W'(1);
      3'd3:    res_o = src_i + W'(2);
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/spill_alu_regop.sv
module spill_alu_regop
  import spill_alu_pkg::*;
#(
  parameter int unsigned B = 8,
  localparam int unsigned W = 2 * B
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic [3:0]   mod_i,
  output logic [W-1:0] res_o,
  output logic         ok_o
);
  logic [B-1:0] d_lo, d_hi, s_lo, s_hi;
  logic [B:0]   add_lo, sub_lo, add_hi;
  logic [W-1:0] mv_res;

  assign d_lo = dst_i[B-1:0];
  assign d_hi = dst_i[W-1:B];
  assign s_lo = src_i[B-1:0];
  assign s_hi = src_i[W-1:B];

  assign add_lo = {1'b0, d_lo} + {1'b0, s_lo};
  assign sub_lo = {1'b0, d_lo} - {1'b0, s_lo};  // msb = borrow
  assign add_hi = {1'b0, d_hi} + {1'b0, s_lo};

  spill_alu_move #(.W(W)) u_move (
    .src_i (src_i),
    .mod_i (mod_i),
    .res_o (mv_res)
  );

  always_comb begin
    ok_o  = 1'b1;
    res_o = dst_i;
    unique case (reg_mod_e'(mod_i))
      M_MVM2, M_MVM1, M_MVP1, M_MVP2, M_MOV: res_o = mv_res;
      M_AND:  res_o = {d_hi, d_lo & s_lo};
      M_OR:   res_o = {d_hi, d_lo | s_lo};
      M_XOR:  res_o = {d_hi, d_lo ^ s_lo};
      M_ADD:  res_o = {d_hi + B'(add_lo[B]), add_lo[B-1:0]};
      M_SUB:  res_o = {d_hi - B'(sub_lo[B]), sub_lo[B-1:0]};
      M_ADS1: res_o = {B'(add_hi[B]), add_hi[B-1:0]};
      M_ADS2: res_o = {{B{~add_hi[B]}}, add_hi[B-1:0]};
      M_H2L:  res_o = {d_hi, s_hi};
      M_L2H:  res_o = {s_lo, d_lo};
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spill_alu_immop.sv
module spill_alu_immop
  import spill_alu_pkg::*;
#(
  parameter int unsigned B = 8,
  localparam int unsigned W = 2 * B
) (
  input  logic [W-1:0] dst_i,
  input  logic [B-1:0] imm_i,
  input  logic [3:0]   op_i,
  input  logic [3:0]   mod_i,
  output logic [W-1:0] res_o,
  output logic         ok_o
);
  logic [B-1:0] d_lo, d_hi;
  logic [B:0]   addi, subi;
  logic [B-1:0] rot [4];  // 0: padded shift, 1..3: rotate by 1, 3, 4

  assign d_lo = dst_i[B-1:0];
  assign d_hi = dst_i[W-1:B];
  assign addi = {1'b0, d_lo} + {1'b0, imm_i} + (B+1)'(1);
  assign subi = {1'b0, d_lo} - {1'b0, imm_i} - (B+1)'(1);  // msb = borrow

  assign rot[0] = {d_hi[0], d_lo[B-1:1]};
  for (genvar g = 1; g < 4; g++) begin : g_rot
    localparam int unsigned AMT = (g == 1) ? 1 : g + 1;
    assign rot[g] = {d_lo[AMT-1:0], d_lo[B-1:AMT]};
  end

  always_comb begin
    ok_o  = 1'b1;
    res_o = dst_i;
    unique case (op_i)
      OP_EMIT: res_o = {d_hi, imm_i};
      OP_CLR:  res_o = {d_hi, d_lo & ~imm_i};
      OP_SET:  res_o = {d_hi, d_lo | imm_i};
      OP_ADDI: res_o = {d_hi + B'(addi[B]), addi[B-1:0]};
      OP_SUBI: res_o = {d_hi - B'(subi[B]), subi[B-1:0]};
      OP_SHFT: begin
        if (mod_i[3:2] == 2'b11) res_o = {d_hi, rot[mod_i[1:0]]};
        else                     ok_o  = 1'b0;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spill_alu.sv
module spill_alu
  import spill_alu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned HW_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [3:0]        mod_i,
  input  logic [HW_W-1:0]   dst_i,
  input  logic [HW_W-1:0]   src_i,
  input  logic [BYTE_W-1:0] imm_i,
  output logic [HW_W-1:0]   result_o,
  output logic              we_o
);
  logic [HW_W-1:0] reg_res, imm_res, nxt_res;
  logic            reg_ok, imm_ok, nxt_ok;

  spill_alu_regop #(.B(BYTE_W)) u_regop (
    .dst_i (dst_i),
    .src_i (src_i),
    .mod_i (mod_i),
    .res_o (reg_res),
    .ok_o  (reg_ok)
  );

  spill_alu_immop #(.B(BYTE_W)) u_immop (
    .dst_i (dst_i),
    .imm_i (imm_i),
    .op_i  (op_i),
    .mod_i (mod_i),
    .res_o (imm_res),
    .ok_o  (imm_ok)
  );

  always_comb begin
    if (op_i == OP_REG) begin
      nxt_res = reg_res;
      nxt_ok  = reg_ok;
    end else begin
      nxt_res = imm_res;
      nxt_ok  = imm_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      we_o     <= 1'b0;
    end else begin
      we_o <= valid_i && nxt_ok;
      if (valid_i && nxt_ok) result_o <= nxt_res;
    end
  end
endmodule

// File: rtl/spill_alu_chk.sv
module spill_alu_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned HW_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [3:0]        mod_i,
  input logic [HW_W-1:0]   dst_i,
  input logic [HW_W-1:0]   src_i,
  input logic [BYTE_W-1:0] imm_i,
  input logic [HW_W-1:0]   result_o,
  input logic              we_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !we_o));

  a_r2_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !we_o);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  a_r3_plain_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h0 && mod_i == 4'h4) |=> (we_o && result_o == $past(src_i)));

  a_r4_logic_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h0 && mod_i >= 4'h5 && mod_i <= 4'h7)
      |=> result_o[HW_W-1:BYTE_W] == $past(dst_i[HW_W-1:BYTE_W]));

  a_r7_carry_hi_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h0 && mod_i == 4'hA) |=> result_o[HW_W-1:BYTE_W] <= 1);

  a_r8_borrow_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h0 && mod_i == 4'hB)
      |=> (result_o[HW_W-1:BYTE_W] == '0 || result_o[HW_W-1:BYTE_W] == '1));

  a_r11_emit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h8) |=> (we_o && result_o[BYTE_W-1:0] == $past(imm_i)));

  a_r12_shift_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'hE && mod_i >= 4'hC)
      |=> result_o[HW_W-1:BYTE_W] == $past(dst_i[HW_W-1:BYTE_W]));

  a_r13_reserved_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h0 && mod_i >= 4'hE) |=> !we_o);
endmodule

bind spill_alu spill_alu_chk #(.BYTE_W(BYTE_W)) i_spill_alu_chk (.*);

// File: tb/test_spill_alu.sv
module test_spill_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0, mod_i = '0;
  logic [15:0] dst_i = '0, src_i = '0;
  logic [7:0]  imm_i = '0;
  logic [15:0] result_o;
  logic        we_o;

  int checks = 0, errors = 0;
  int exp_res = 0;
  bit exp_we = 0;
  string exp_tag = "R1";
  bit done = 0;

  always #5 clk_i = ~clk_i;

  spill_alu i_spill_alu (.*);

  function automatic string tag_of(input int op, input int md);
    if (op == 0) begin
      if (md <= 4) return "R3";
      if (md <= 7) return "R4";
      if (md == 8) return "R5";
      if (md == 9) return "R6";
      if (md == 10) return "R7";
      if (md == 11) return "R8";
      if (md <= 13) return "R9";
      return "R13";
    end
    if (op == 10 || op == 15) return "R10";
    if (op == 8 || op == 9 || op == 11) return "R11";
    if (op == 14 && md >= 12) return "R12";
    return "R13";
  endfunction

  // behavioural model: ok=0 means no write
  function automatic void model(input int op, input int md, input int dst, input int src,
                                input int imm, output bit ok, output int res);
    int hi, lo, shi, slo, t, n;
    hi = dst / 256; lo = dst % 256; shi = src / 256; slo = src % 256;
    ok = 1; res = dst;
    if (op == 0) begin
      case (md)
        0: res = (src + 65536 - 2) % 65536;
        1: res = (src + 65536 - 1) % 65536;
        2: res = (src + 1) % 65536;
        3: res = (src + 2) % 65536;
        4: res = src;
        5: res = hi * 256 + (lo & slo);
        6: res = hi * 256 + (lo | slo);
        7: res = hi * 256 + (lo ^ slo);
        8: begin t = lo + slo; if (t > 255) hi = (hi + 1) % 256; res = hi * 256 + t % 256; end
        9: begin t = lo - slo; if (t < 0) begin t += 256; hi = (hi + 255) % 256; end res = hi * 256 + t; end
        10: begin t = hi + slo; res = (t > 255 ? 256 : 0) + t % 256; end
        11: begin t = hi + slo; res = (t > 255 ? 0 : 255 * 256) + t % 256; end
        12: res = hi * 256 + shi;
        13: res = slo * 256 + lo;
        default: ok = 0;
      endcase
    end else if (op == 8) res = hi * 256 + imm;
    else if (op == 9) res = hi * 256 + (lo & (255 - imm));
    else if (op == 11) res = hi * 256 + (lo | imm);
    else if (op == 10) begin
      t = lo + imm + 1; if (t > 255) hi = (hi + 1) % 256; res = hi * 256 + t % 256;
    end else if (op == 15) begin
      t = lo - imm - 1; if (t < 0) begin t += 256; hi = (hi + 255) % 256; end res = hi * 256 + t;
    end else if (op == 14 && md >= 12) begin
      if (md == 12) res = hi * 256 + (hi % 2) * 128 + lo / 2;
      else begin
        n = (md == 13) ? 1 : md - 11;
        t = lo;
        for (int k = 0; k < n; k++) t = (t % 2) * 128 + t / 2;
        res = hi * 256 + t;
      end
    end else ok = 0;
  endfunction

  task automatic check_out();
    checks++;
    if (we_o !== exp_we || result_o !== 16'(exp_res)) begin
      errors++;
      $display("FAIL %s: we=%0b result=%04h expected we=%0b result=%04h",
               exp_tag, we_o, result_o, exp_we, 16'(exp_res));
    end
  endtask

  // apply at negedge, compare one cycle later at the next negedge
  task automatic step(input bit v, input int op, input int md, input int dst,
                      input int src, input int imm);
    bit ok; int r;
    valid_i = v; op_i = 4'(op); mod_i = 4'(md);
    dst_i = 16'(dst); src_i = 16'(src); imm_i = 8'(imm);
    model(op, md, dst, src, imm, ok, r);
    if (v) begin
      exp_tag = tag_of(op, md);
      exp_we = ok;
      if (ok) exp_res = r;
    end else begin
      exp_tag = "R2";
      exp_we = 0;
    end
    @(negedge clk_i);
    check_out();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    exp_tag = "R1"; exp_we = 0; exp_res = 0;
    check_out();  // R1 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 move offsets and wrap
    step(1, 0, 0, 16'h1234, 16'h0000, 0);
    step(1, 0, 1, 16'h1234, 16'h0000, 0);
    step(1, 0, 2, 16'h1234, 16'hFFFF, 0);
    step(1, 0, 3, 16'h1234, 16'hFFFE, 0);
    step(1, 0, 4, 16'h1234, 16'hBEEF, 0);
    // R4 logic
    step(1, 0, 5, 16'hA5F0, 16'h773C, 0);
    step(1, 0, 6, 16'hA5F0, 16'h773C, 0);
    step(1, 0, 7, 16'hA5F0, 16'h773C, 0);
    // R5 carry, incl high byte wrap
    step(1, 0, 8, 16'h00FF, 16'h0001, 0);
    step(1, 0, 8, 16'hFFFF, 16'h0001, 0);
    step(1, 0, 8, 16'h1210, 16'h0020, 0);
    // R6 borrow
    step(1, 0, 9, 16'h0000, 16'h0001, 0);
    step(1, 0, 9, 16'h0550, 16'h0010, 0);
    // R7 / R8 with and without carry
    step(1, 0, 10, 16'h0180, 16'h0005, 0);
    step(1, 0, 10, 16'hF080, 16'h0020, 0);
    step(1, 0, 11, 16'h0180, 16'h0005, 0);
    step(1, 0, 11, 16'hF080, 16'h0020, 0);
    // R9
    step(1, 0, 12, 16'h1122, 16'hABCD, 0);
    step(1, 0, 13, 16'h1122, 16'hABCD, 0);
    // R10 immediates incl imm=0 and borrow
    step(1, 10, 0, 16'h00FF, 0, 8'h00);
    step(1, 10, 0, 16'h0310, 0, 8'h0F);
    step(1, 15, 0, 16'h0300, 0, 8'h00);
    step(1, 15, 0, 16'h0320, 0, 8'h0F);
    // R11
    step(1, 8, 0, 16'h9A00, 0, 8'h5C);
    step(1, 9, 0, 16'h9AFF, 0, 8'hAC);
    step(1, 11, 0, 16'h9A00, 0, 8'hAC);
    // R12 padded shift with hi bit0 set/clear, rotates
    step(1, 14, 12, 16'h01D1, 0, 0);
    step(1, 14, 12, 16'h02D1, 0, 0);
    step(1, 14, 13, 16'h02D1, 0, 0);
    step(1, 14, 14, 16'h55D1, 0, 0);
    step(1, 14, 15, 16'h55D1, 0, 0);
    // R13 rejected codes hold result
    step(1, 0, 14, 16'h1111, 16'h2222, 0);
    step(1, 14, 3, 16'h1111, 16'h2222, 0);
    step(1, 5, 0, 16'h1111, 16'h2222, 0);
    // R2 idle
    step(0, 0, 4, 16'h1111, 16'h7777, 0);
    // random stream, all checked against the model
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % 16, $urandom % 16,
           $urandom % 65536, $urandom % 65536, $urandom % 256);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule